// File: doc/BRIEF.md
# Trap Condition Checker

This unit decides whether a bounds-checking or conditional-trap instruction must raise an exception. Each request carries an operation code, an operand size, the register value, two bound operands, a condition selector and the current N/Z/V/C flags. One clock edge after the request, the unit reports whether a trap is requested and which exception vector to use. For the dual-bound check it also reports a zero flag and a carry flag.

Four operations are folded into one checker:

- A signed single-bound check of a register against zero and an upper limit.
- A dual-bound range check at byte, word or long size, with a choice of signed or unsigned comparison.
- A trap on any of the sixteen standard condition predicates.
- A trap on the overflow flag.

Fetching the operands and stacking the exception frame are the job of the surrounding pipeline.

Top module: `trap_check_unit`

## Requirements
- R1: While `rstN` is low, `resultValid`, `trapReq`, `flagZ` and `flagC` are 0 and `trapVector` is 0.
- R2: A request (`reqValid`=1 at a rising edge) produces `resultValid`=1 after exactly that edge. With no request at an edge, every result output is 0 after that edge, whatever the other inputs are.
- R3: Operation code 0 is the single-bound check. It is always signed, and it works at word size (`sizeSel`=1, also used when `sizeSel`=0) or long size (`sizeSel`=2 or 3). It traps when the sign-extended value is negative or greater than the sign-extended upper bound. A value equal to the bound does not trap.
- R4: Operation code 1 is the dual-bound check at byte (`sizeSel`=0), word (1) or long (2 or 3) size. Only the low bits of the selected width of the value and both bounds are used. It traps when the value is below `lowBound` or above `highBound`.
- R5: For the dual-bound check, `signedMode`=1 sign-extends the selected width and compares signed. `signedMode`=0 zero-extends and compares unsigned.
- R6: For the dual-bound check, `flagC`=1 exactly when the value is out of range, and `flagZ`=1 exactly when the value equals either bound. For every other operation both flags are 0.
- R7: Operation code 2 traps when the predicate named by `condSel` holds. The flags are `flagsIn`={N,Z,V,C} (bit 3 down to bit 0). The predicates by code are:
  - 0: true
  - 1: false
  - 2: !C&!Z
  - 3: C|Z
  - 4: !C
  - 5: C
  - 6: !Z
  - 7: Z
  - 8: !V
  - 9: V
  - 10: !N
  - 11: N
  - 12: N==V
  - 13: N!=V
  - 14: !Z&(N==V)
  - 15: Z|(N!=V)
- R8: Operation code 3 traps exactly when V (`flagsIn[1]`) is 1.
- R9: `trapVector` is 6 for a trap from operation 0 or 1, 7 for a trap from operation 2 or 3, and 0 when no trap is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Evaluate the operands at this edge |
| opSel | input | 2 | 0 single-bound, 1 dual-bound, 2 condition trap, 3 overflow trap |
| sizeSel | input | 2 | 0 byte, 1 word, 2 and 3 long |
| signedMode | input | 1 | Dual-bound comparison: 1 signed, 0 unsigned |
| regVal | input | DATA_W | Value under test |
| lowBound | input | DATA_W | Lower bound (dual-bound only) |
| highBound | input | DATA_W | Upper bound |
| condSel | input | 4 | Condition predicate selector |
| flagsIn | input | 4 | Current flags {N,Z,V,C} |
| resultValid | output | 1 | Result outputs are valid this cycle |
| trapReq | output | 1 | An exception must be raised |
| trapVector | output | VEC_W | Exception vector number |
| flagZ | output | 1 | Dual-bound: value equals a bound |
| flagC | output | 1 | Dual-bound: value out of range |

## Verification
The bench builds the unit with its default parameters: a 32-bit long lane over 8-bit and 16-bit lanes, and an 8-bit vector with numbers 6 and 7. With these values, the directed operands can place upper-lane garbage above a byte or word operand. This shows that only the selected lane is compared. The same operand bytes are then read as signed and as unsigned, so both readings of one bit pattern give different range outcomes. The condition trap is swept over all sixteen selectors against several flag patterns, and the equal-to-bound edges are exercised at every lane width.

// File: rtl/trapchk_pkg.sv
package trapchk_pkg;

  typedef enum logic [1:0] {
    OP_SINGLE = 2'd0,
    OP_DUAL   = 2'd1,
    OP_COND   = 2'd2,
    OP_OVF    = 2'd3
  } trapOp_e;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_WORD  = 2'd1,
    SZ_LONG  = 2'd2,
    SZ_LONGX = 2'd3
  } opSize_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic    capture;
    logic    selSingle;
    logic    selDual;
    logic    selCond;
    logic    selOvf;
    logic    signExt;
    opSize_e size;
  } dpStrobe_t;

  // flags = {N,Z,V,C}
  function automatic logic condHolds(input logic [3:0] sel, input logic [3:0] flags);
    logic n, z, v, c;
    n = flags[3];
    z = flags[2];
    v = flags[1];
    c = flags[0];
    case (sel)
      4'd0:    return 1'b1;
      4'd1:    return 1'b0;
      4'd2:    return !c && !z;
      4'd3:    return c || z;
      4'd4:    return !c;
      4'd5:    return c;
      4'd6:    return !z;
      4'd7:    return z;
      4'd8:    return !v;
      4'd9:    return v;
      4'd10:   return !n;
      4'd11:   return n;
      4'd12:   return n == v;
      4'd13:   return n != v;
      4'd14:   return !z && (n == v);
      default: return z || (n != v);
    endcase
  endfunction

endpackage

// File: rtl/trapchk_ctrl.sv
module trapchk_ctrl
  import trapchk_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic [1:0] opSel,
  input  logic [1:0] sizeSel,
  input  logic       signedMode,
  output dpStrobe_t  strobe,
  output logic       resultValid
);

  trapOp_e op;
  opSize_e reqSize;

  assign op      = trapOp_e'(opSel);
  assign reqSize = opSize_e'(sizeSel);

  always_comb begin
    strobe           = '0;
    strobe.capture   = reqValid;
    strobe.selSingle = (op == OP_SINGLE);
    strobe.selDual   = (op == OP_DUAL);
    strobe.selCond   = (op == OP_COND);
    strobe.selOvf    = (op == OP_OVF);
    // single-bound compare is always signed and has no byte lane
    strobe.signExt   = (op == OP_SINGLE) ? 1'b1 : signedMode;
    if (op == OP_SINGLE && reqSize == SZ_BYTE) strobe.size = SZ_WORD;
    else                                       strobe.size = reqSize;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) resultValid <= 1'b0;
    else       resultValid <= reqValid;
  end

endmodule

// File: rtl/trapchk_dp.sv
module trapchk_dp
  import trapchk_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BYTE_W    = 8,
  parameter int WORD_W    = 16,
  parameter int VEC_W     = 8,
  parameter int VEC_BOUND = 6,
  parameter int VEC_COND  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [DATA_W-1:0] regVal,
  input  logic [DATA_W-1:0] lowBound,
  input  logic [DATA_W-1:0] highBound,
  input  logic [3:0]        condSel,
  input  logic [3:0]        flagsIn,
  output logic              trapReq,
  output logic [VEC_W-1:0]  trapVector,
  output logic              flagZ,
  output logic              flagC
);

  localparam int EXT_W     = DATA_W + 1;
  localparam int NUM_LANES = 3;
  localparam logic [VEC_W-1:0] BOUND_VEC = VEC_W'(VEC_BOUND);
  localparam logic [VEC_W-1:0] COND_VEC  = VEC_W'(VEC_COND);

  logic [EXT_W-1:0] valLane  [NUM_LANES];
  logic [EXT_W-1:0] lowLane  [NUM_LANES];
  logic [EXT_W-1:0] highLane [NUM_LANES];

  for (genvar g = 0; g < NUM_LANES; g++) begin : gLane
    localparam int LW = (g == 0) ? BYTE_W : (g == 1) ? WORD_W : DATA_W;
    assign valLane[g]  = {{(EXT_W-LW){strobe.signExt & regVal[LW-1]}},    regVal[LW-1:0]};
    assign lowLane[g]  = {{(EXT_W-LW){strobe.signExt & lowBound[LW-1]}},  lowBound[LW-1:0]};
    assign highLane[g] = {{(EXT_W-LW){strobe.signExt & highBound[LW-1]}}, highBound[LW-1:0]};
  end

  logic [EXT_W-1:0] valX, lowX, highX;
  logic [1:0]       laneIdx;

  always_comb begin
    case (strobe.size)
      SZ_BYTE: laneIdx = 2'd0;
      SZ_WORD: laneIdx = 2'd1;
      default: laneIdx = 2'd2;
    endcase
    valX  = valLane[laneIdx];
    lowX  = lowLane[laneIdx];
    highX = highLane[laneIdx];
  end

  logic belowLow, aboveHigh, isNeg, onBound, condTrue;

  assign belowLow  = $signed(valX) < $signed(lowX);
  assign aboveHigh = $signed(valX) > $signed(highX);
  assign isNeg     = valX[EXT_W-1];
  assign onBound   = (valX == lowX) || (valX == highX);
  assign condTrue  = condHolds(condSel, flagsIn);

  logic             trapNext, zNext, cNext;
  logic [VEC_W-1:0] vecNext;

  always_comb begin
    trapNext = 1'b0;
    zNext    = 1'b0;
    cNext    = 1'b0;
    vecNext  = '0;
    if (strobe.selSingle) begin
      trapNext = isNeg || aboveHigh;
      vecNext  = trapNext ? BOUND_VEC : '0;
    end else if (strobe.selDual) begin
      trapNext = belowLow || aboveHigh;
      cNext    = trapNext;
      zNext    = onBound;
      vecNext  = trapNext ? BOUND_VEC : '0;
    end else if (strobe.selCond) begin
      trapNext = condTrue;
      vecNext  = trapNext ? COND_VEC : '0;
    end else if (strobe.selOvf) begin
      trapNext = flagsIn[1];
      vecNext  = trapNext ? COND_VEC : '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trapReq    <= 1'b0;
      trapVector <= '0;
      flagZ      <= 1'b0;
      flagC      <= 1'b0;
    end else if (strobe.capture) begin
      trapReq    <= trapNext;
      trapVector <= vecNext;
      flagZ      <= zNext;
      flagC      <= cNext;
    end else begin
      trapReq    <= 1'b0;
      trapVector <= '0;
      flagZ      <= 1'b0;
      flagC      <= 1'b0;
    end
  end

endmodule

// File: rtl/trap_check_unit.sv
module trap_check_unit
  import trapchk_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int BYTE_W    = 8,
  parameter int WORD_W    = 16,
  parameter int VEC_W     = 8,
  parameter int VEC_BOUND = 6,
  parameter int VEC_COND  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [1:0]        opSel,
  input  logic [1:0]        sizeSel,
  input  logic              signedMode,
  input  logic [DATA_W-1:0] regVal,
  input  logic [DATA_W-1:0] lowBound,
  input  logic [DATA_W-1:0] highBound,
  input  logic [3:0]        condSel,
  input  logic [3:0]        flagsIn,
  output logic              resultValid,
  output logic              trapReq,
  output logic [VEC_W-1:0]  trapVector,
  output logic              flagZ,
  output logic              flagC
);

  dpStrobe_t strobe;

  trapchk_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .opSel       (opSel),
    .sizeSel     (sizeSel),
    .signedMode  (signedMode),
    .strobe      (strobe),
    .resultValid (resultValid)
  );

  trapchk_dp #(
    .DATA_W    (DATA_W),
    .BYTE_W    (BYTE_W),
    .WORD_W    (WORD_W),
    .VEC_W     (VEC_W),
    .VEC_BOUND (VEC_BOUND),
    .VEC_COND  (VEC_COND)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .regVal     (regVal),
    .lowBound   (lowBound),
    .highBound  (highBound),
    .condSel    (condSel),
    .flagsIn    (flagsIn),
    .trapReq    (trapReq),
    .trapVector (trapVector),
    .flagZ      (flagZ),
    .flagC      (flagC)
  );

endmodule

// File: rtl/trapchk_props.sv
module trapchk_props #(
  parameter int VEC_W     = 8,
  parameter int VEC_BOUND = 6,
  parameter int VEC_COND  = 7
) (
  input logic             clk,
  input logic             rstN,
  input logic             reqValid,
  input logic [1:0]       opSel,
  input logic [3:0]       condSel,
  input logic [3:0]       flagsIn,
  input logic             resultValid,
  input logic             trapReq,
  input logic [VEC_W-1:0] trapVector,
  input logic             flagZ,
  input logic             flagC
);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |-> (!resultValid && !trapReq && trapVector == '0 && !flagZ && !flagC));

  // R2
  req_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> resultValid);

  // R2
  idle_silent_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!resultValid && !trapReq && !flagZ && !flagC));

  // R6
  dual_carry_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opSel == 2'd1) |=> (flagC == trapReq));

  // R6
  other_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opSel != 2'd1) |=> (!flagZ && !flagC));

  // R7
  always_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opSel == 2'd2 && condSel == 4'd0) |=> trapReq);

  // R7
  never_cond_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opSel == 2'd2 && condSel == 4'd1) |=> !trapReq);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && opSel == 2'd3) |=> (trapReq == $past(flagsIn[1])));

  // R9
  vec_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> (trapVector == VEC_W'(VEC_BOUND) || trapVector == VEC_W'(VEC_COND)));

  // R9
  vec_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !trapReq |-> (trapVector == '0));

endmodule

bind trap_check_unit trapchk_props #(
  .VEC_W     (VEC_W),
  .VEC_BOUND (VEC_BOUND),
  .VEC_COND  (VEC_COND)
) u_props (
  .clk         (clk),
  .rstN        (rstN),
  .reqValid    (reqValid),
  .opSel       (opSel),
  .condSel     (condSel),
  .flagsIn     (flagsIn),
  .resultValid (resultValid),
  .trapReq     (trapReq),
  .trapVector  (trapVector),
  .flagZ       (flagZ),
  .flagC       (flagC)
);

// File: tb/sim_trap_check_unit.sv
`timescale 1ns/1ps
module sim_trap_check_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  opSel = 2'd0;
  logic [1:0]  sizeSel = 2'd0;
  logic        signedMode = 1'b0;
  logic [31:0] regVal = '0;
  logic [31:0] lowBound = '0;
  logic [31:0] highBound = '0;
  logic [3:0]  condSel = '0;
  logic [3:0]  flagsIn = '0;
  logic        resultValid, trapReq, flagZ, flagC;
  logic [7:0]  trapVector;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  always #4 clk = ~clk;

  trap_check_unit u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .opSel(opSel), .sizeSel(sizeSel),
    .signedMode(signedMode), .regVal(regVal), .lowBound(lowBound), .highBound(highBound),
    .condSel(condSel), .flagsIn(flagsIn), .resultValid(resultValid), .trapReq(trapReq),
    .trapVector(trapVector), .flagZ(flagZ), .flagC(flagC)
  );

  task automatic check(input string tag, input string what, input int actual, input int expected);
    checkCount++;
    if (actual != expected) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, actual, expected);
    end
  endtask

  // Drive at a falling edge, sample at the next falling edge.
  task automatic runOp(input logic [1:0] op, input logic [1:0] sz, input logic sgn,
                       input logic [31:0] v, input logic [31:0] lo, input logic [31:0] hi,
                       input logic [3:0] cs, input logic [3:0] fl);
    opSel = op; sizeSel = sz; signedMode = sgn;
    regVal = v; lowBound = lo; highBound = hi; condSel = cs; flagsIn = fl;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expectAll(input string tag, input int trap, input int vec, input int z, input int c);
    check(tag, "resultValid", int'(resultValid), 1);
    check(tag, "trapReq", int'(trapReq), trap);
    check(tag, "trapVector", int'(trapVector), vec);
    check(tag, "flagZ", int'(flagZ), z);
    check(tag, "flagC", int'(flagC), c);
  endtask

  function automatic int refCond(input int code, input logic [3:0] f);
    logic n, z, v, c;
    n = f[3]; z = f[2]; v = f[1]; c = f[0];
    case (code)
      0: return 1;
      1: return 0;
      2: return int'(!c && !z);
      3: return int'(c || z);
      4: return int'(!c);
      5: return int'(c);
      6: return int'(!z);
      7: return int'(z);
      8: return int'(!v);
      9: return int'(v);
      10: return int'(!n);
      11: return int'(n);
      12: return int'(n == v);
      13: return int'(n != v);
      14: return int'(!z && (n == v));
      default: return int'(z || (n != v));
    endcase
  endfunction

  task automatic testReset();
    check("R1", "resultValid", int'(resultValid), 0);
    check("R1", "trapReq", int'(trapReq), 0);
    check("R1", "trapVector", int'(trapVector), 0);
    check("R1", "flagZ/flagC", int'({flagZ, flagC}), 0);
  endtask

  task automatic testIdle();
    // inputs that would trap, but no request
    opSel = 2'd3; flagsIn = 4'b0010; reqValid = 1'b0;
    @(negedge clk);
    check("R2", "idle resultValid", int'(resultValid), 0);
    check("R2", "idle trapReq", int'(trapReq), 0);
    check("R2", "idle trapVector", int'(trapVector), 0);
    runOp(2'd3, 2'd2, 1'b0, 0, 0, 0, 0, 4'b0010);
    check("R2", "latency resultValid", int'(resultValid), 1);
    @(negedge clk);
    check("R2", "drop resultValid", int'(resultValid), 0);
    check("R2", "drop trapReq", int'(trapReq), 0);
  endtask

  task automatic testSingle();
    runOp(2'd0, 2'd1, 1'b0, 32'h5, 0, 32'hA, 0, 0);
    expectAll("R3 in range", 0, 0, 0, 0);
    runOp(2'd0, 2'd1, 1'b0, 32'hA, 0, 32'hA, 0, 0);
    expectAll("R3 equal bound", 0, 0, 0, 0);
    runOp(2'd0, 2'd1, 1'b0, 32'hB, 0, 32'hA, 0, 0);
    expectAll("R3 R9 above bound", 1, 6, 0, 0);
    runOp(2'd0, 2'd1, 1'b0, 32'h0000_FFFF, 0, 32'h7FFF, 0, 0);
    expectAll("R3 negative word", 1, 6, 0, 0);
    runOp(2'd0, 2'd2, 1'b0, 32'h0000_FFFF, 0, 32'h0001_0000, 0, 0);
    expectAll("R3 long positive", 0, 0, 0, 0);
    runOp(2'd0, 2'd1, 1'b0, 32'hABCD_0003, 0, 32'h1234_0004, 0, 0);
    expectAll("R3 upper bits ignored", 0, 0, 0, 0);
    runOp(2'd0, 2'd0, 1'b0, 32'h0080, 0, 32'h0100, 0, 0);
    expectAll("R3 byte as word", 0, 0, 0, 0);
    runOp(2'd0, 2'd3, 1'b0, 32'h8000_0000, 0, 32'h7FFF_FFFF, 0, 0);
    expectAll("R3 negative long", 1, 6, 0, 0);
  endtask

  task automatic testDual();
    runOp(2'd1, 2'd0, 1'b1, 32'h05, 32'hF0, 32'h10, 0, 0);
    expectAll("R4 R5 byte signed inside", 0, 0, 0, 0);
    runOp(2'd1, 2'd0, 1'b0, 32'h05, 32'hF0, 32'h10, 0, 0);
    expectAll("R5 R6 byte unsigned below", 1, 6, 0, 1);
    runOp(2'd1, 2'd0, 1'b1, 32'hFFFF_FF10, 32'h1234_56F0, 32'h9999_9910, 0, 0);
    expectAll("R4 R6 byte on high bound", 0, 0, 1, 0);
    runOp(2'd1, 2'd0, 1'b1, 32'h11, 32'hF0, 32'h10, 0, 0);
    expectAll("R4 R6 byte above", 1, 6, 0, 1);
    runOp(2'd1, 2'd1, 1'b0, 32'h0200, 32'h0100, 32'h8000, 0, 0);
    expectAll("R5 word unsigned inside", 0, 0, 0, 0);
    runOp(2'd1, 2'd1, 1'b1, 32'h0200, 32'h0100, 32'h8000, 0, 0);
    expectAll("R5 word signed outside", 1, 6, 0, 1);
    runOp(2'd1, 2'd2, 1'b1, 32'hFFFF_FF00, 32'hFFFF_FF00, 32'h0000_0100, 0, 0);
    expectAll("R4 R6 long on low bound", 0, 0, 1, 0);
    runOp(2'd1, 2'd2, 1'b1, 32'h8000_0000, 32'hFFFF_FF00, 32'h0000_0100, 0, 0);
    expectAll("R4 long below", 1, 6, 0, 1);
    runOp(2'd1, 2'd3, 1'b0, 32'hFFFF_FF00, 32'hFFFF_FF00, 32'h0000_0100, 0, 0);
    expectAll("R5 R6 long unsigned above on low", 1, 6, 1, 1);
  endtask

  task automatic testCond();
    logic [3:0] pats [7] = '{4'b0000, 4'b1111, 4'b1000, 4'b0100, 4'b0010, 4'b0001, 4'b1010};
    for (int p = 0; p < 7; p++) begin
      for (int code = 0; code < 16; code++) begin
        runOp(2'd2, 2'd0, 1'b0, 0, 0, 0, 4'(code), pats[p]);
        check($sformatf("R7 cc%0d flags%b", code, pats[p]), "trapReq", int'(trapReq), refCond(code, pats[p]));
        check("R9 cond vector", "trapVector", int'(trapVector), refCond(code, pats[p]) != 0 ? 7 : 0);
        check("R6 cond flags", "flagZ/flagC", int'({flagZ, flagC}), 0);
      end
    end
  endtask

  task automatic testOvf();
    runOp(2'd3, 2'd0, 1'b0, 0, 0, 0, 0, 4'b0010);
    expectAll("R8 R9 V set", 1, 7, 0, 0);
    runOp(2'd3, 2'd0, 1'b0, 0, 0, 0, 0, 4'b1101);
    expectAll("R8 V clear", 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testIdle();
    testSingle();
    testDual();
    testCond();
    testOvf();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule